// File: doc/BRIEF.md
# UART Sticky Interrupt Status Controller

This block gathers fourteen event sources of one serial channel into a sticky status word and raises a single active-high, level-sensitive interrupt line. The sources are single-cycle pulses or held levels coming from the FIFOs, the framing logic and the bus interface. Once a source asserts, its status bit stays set until software acknowledges it by writing a one to that bit. Software can return the word it has just read to acknowledge every pending bit at once.

A mask word with the same bit layout as the status word decides which latched bits reach the interrupt line. Status bits latch whether or not they are masked, so unmasking a pending bit raises the interrupt straight away. Besides whole-word mask writes, the receive group and the transmit group of mask bits can each be switched on or off as a unit with single strobes. Register access is modelled as address-free write strobes, each with a data word, and the two words are always visible on outputs.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, status_o and enable_o are all zeros and irq_o is low.
- R2: A high level on evt_i[k] in a cycle sets status_o[k] at the next rising clock edge. The bit stays set after the source drops. A status bit never rises without its source.
- R3: A cycle with sts_wr_i high clears, at the next edge, every status bit whose sts_wdata_i bit is one and leaves the others unchanged. Writing back the value read clears all pending bits.
- R4: If evt_i[k] is high in the same cycle as a write-one-to-clear of bit k, status_o[k] stays set.
- R5: A cycle with en_wr_i high loads en_wdata_i into enable_o at the next edge. With no enable strobe, enable_o holds.
- R6: irq_o is high exactly when some bit is set in both status_o and enable_o, in the same cycle those registers change.
- R7: Status bits latch while masked. Setting the mask of a pending bit raises irq_o at that write's edge.
- R8: rx_grp_on_i sets and rx_grp_off_i clears the receive-group mask bits 4, 5, 7, 8, 9 and 11 (mask 0x0BB0). Other mask bits are unchanged.
- R9: tx_grp_on_i sets and tx_grp_off_i clears the transmit-group mask bits 2, 3 and 6 (mask 0x004C). Other mask bits are unchanged.
- R10: Group strobes apply after a whole-word mask write in the same cycle, and a group's off strobe wins over its on strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Event sources, one per status bit |
| sts_wr_i | input | 1 | Status write strobe (write one to clear) |
| sts_wdata_i | input | 14 | Status write data |
| en_wr_i | input | 1 | Mask word write strobe |
| en_wdata_i | input | 14 | Mask word write data |
| rx_grp_on_i | input | 1 | Set all receive-group mask bits |
| rx_grp_off_i | input | 1 | Clear all receive-group mask bits |
| tx_grp_on_i | input | 1 | Set all transmit-group mask bits |
| tx_grp_off_i | input | 1 | Clear all transmit-group mask bits |
| status_o | output | 14 | Sticky status word |
| enable_o | output | 14 | Interrupt mask word |
| irq_o | output | 1 | Level-sensitive interrupt, active high |

## Verification
Status and mask updates appear one clock after the cycle that carries the event or strobe. irq_o follows those registers with no further delay, so it is due in the same cycle. The bench drives each stimulus just after a rising edge. It reads the outputs two time units after the next rising edge, which is the first moment the update is visible. A behavioural reference model steps on the same edges and is compared on every falling edge. The same-cycle collisions, an event against a clear and an on strobe against an off strobe, get directed checks with precomputed words.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 14;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum int {
    SRC_TX_HOLD_EMPTY = 0,
    SRC_RX_HOLD_FULL  = 1,
    SRC_TXF_LOW       = 2,
    SRC_TXF_EMPTY     = 3,
    SRC_RXF_HIGH      = 4,
    SRC_RXF_FULL      = 5,
    SRC_TX_UNDERRUN   = 6,
    SRC_RX_OVERRUN    = 7,
    SRC_PARITY_ERR    = 8,
    SRC_FRAME_ERR     = 9,
    SRC_CTS_DELTA     = 10,
    SRC_RX_IDLE_TMO   = 11,
    SRC_BREAK_END     = 12,
    SRC_BUS_ERR       = 13
  } src_idx_e;

  function automatic src_vec_t bit_of(src_idx_e idx);
    src_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  localparam src_vec_t RX_GROUP = bit_of(SRC_RXF_HIGH) | bit_of(SRC_RXF_FULL) |
                                  bit_of(SRC_RX_OVERRUN) | bit_of(SRC_PARITY_ERR) |
                                  bit_of(SRC_FRAME_ERR) | bit_of(SRC_RX_IDLE_TMO);
  localparam src_vec_t TX_GROUP = bit_of(SRC_TXF_LOW) | bit_of(SRC_TXF_EMPTY) |
                                  bit_of(SRC_TX_UNDERRUN);
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  logic     wr_i,
  input  src_vec_t wdata_i,
  output src_vec_t q_o
);
  src_vec_t clr;
  assign clr = {NUM_SRC{wr_i}} & wdata_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    // set wins over acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q_o[g] <= 1'b0;
      else if (evt_i[g])    q_o[g] <= 1'b1;
      else if (clr[g])      q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  src_vec_t wdata_i,
  input  logic     rx_on_i,
  input  logic     rx_off_i,
  input  logic     tx_on_i,
  input  logic     tx_off_i,
  output src_vec_t q_o
);
  src_vec_t nxt;

  // word write, then group sets, then group clears
  always_comb begin
    nxt = wr_i ? wdata_i : q_o;
    if (rx_on_i)  nxt = nxt | RX_GROUP;
    if (tx_on_i)  nxt = nxt | TX_GROUP;
    if (rx_off_i) nxt = nxt & ~RX_GROUP;
    if (tx_off_i) nxt = nxt & ~TX_GROUP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/uart_irq_reduce.sv
module uart_irq_reduce
  import uart_irq_pkg::*;
(
  input  src_vec_t status_i,
  input  src_vec_t enable_i,
  output logic     irq_o
);
  assign irq_o = |(status_i & enable_i);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              sts_wr_i,
  input  logic [NUM_SRC-1:0] sts_wdata_i,
  input  logic              en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic              rx_grp_on_i,
  input  logic              rx_grp_off_i,
  input  logic              tx_grp_on_i,
  input  logic              tx_grp_off_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic              irq_o
);
  src_vec_t sts_q, en_q;

  uart_irq_sticky u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .wr_i    (sts_wr_i),
    .wdata_i (sts_wdata_i),
    .q_o     (sts_q)
  );

  uart_irq_mask u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (en_wr_i),
    .wdata_i  (en_wdata_i),
    .rx_on_i  (rx_grp_on_i),
    .rx_off_i (rx_grp_off_i),
    .tx_on_i  (tx_grp_on_i),
    .tx_off_i (tx_grp_off_i),
    .q_o      (en_q)
  );

  uart_irq_reduce u_reduce (
    .status_i (sts_q),
    .enable_i (en_q),
    .irq_o    (irq_o)
  );

  assign status_o = sts_q;
  assign enable_o = en_q;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
  import uart_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               sts_wr_i,
  input logic [NUM_SRC-1:0] sts_wdata_i,
  input logic               en_wr_i,
  input logic               rx_grp_on_i,
  input logic               rx_grp_off_i,
  input logic               tx_grp_on_i,
  input logic               tx_grp_off_i,
  input logic [NUM_SRC-1:0] status_o,
  input logic [NUM_SRC-1:0] enable_o,
  input logic               irq_o
);
  logic [NUM_SRC-1:0] ack;
  logic               any_en_op;
  assign ack       = sts_wr_i ? sts_wdata_i : '0;
  assign any_en_op = en_wr_i | rx_grp_on_i | rx_grp_off_i | tx_grp_on_i | tx_grp_off_i;

  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_i) & ~status_o) == '0)); // R2
  AST_NO_PHANTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(evt_i)) == '0)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~$past(ack) & ~status_o) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(ack) & ~$past(evt_i)) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en_op |=> $stable(enable_o)); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((status_o & enable_o) != '0)); // R6
  AST_RX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_grp_off_i |=> ((enable_o & RX_GROUP) == '0)); // R8
  AST_TX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grp_off_i |=> ((enable_o & TX_GROUP) == '0)); // R9
  AST_RX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_grp_on_i && !rx_grp_off_i) |=> ((enable_o & RX_GROUP) == RX_GROUP)); // R10
endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_i        (evt_i),
  .sts_wr_i     (sts_wr_i),
  .sts_wdata_i  (sts_wdata_i),
  .en_wr_i      (en_wr_i),
  .rx_grp_on_i  (rx_grp_on_i),
  .rx_grp_off_i (rx_grp_off_i),
  .tx_grp_on_i  (tx_grp_on_i),
  .tx_grp_off_i (tx_grp_off_i),
  .status_o     (status_o),
  .enable_o     (enable_o),
  .irq_o        (irq_o)
);

// File: tb/tb_uart_irq_status.sv
`timescale 1ns/1ps
module tb_uart_irq_status;
  localparam int N = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] evt = '0, sts_wd = '0, en_wd = '0;
  logic sts_wr = 1'b0, en_wr = 1'b0;
  logic rx_on = 1'b0, rx_off = 1'b0, tx_on = 1'b0, tx_off = 1'b0;
  logic [N-1:0] status, enable;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_sts, m_en;
  int rx_bits[6] = '{4, 5, 7, 8, 9, 11};
  int tx_bits[3] = '{2, 3, 6};

  always #4 clk = ~clk; // 125 MHz

  uart_irq_status dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt),
    .sts_wr_i(sts_wr), .sts_wdata_i(sts_wd),
    .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .rx_grp_on_i(rx_on), .rx_grp_off_i(rx_off),
    .tx_grp_on_i(tx_on), .tx_grp_off_i(tx_off),
    .status_o(status), .enable_o(enable), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sts = 0;
      m_en  = 0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (evt[k]) m_sts = m_sts | (1 << k);
        else if (sts_wr && sts_wd[k]) m_sts = m_sts & ~(1 << k);
      end
      if (en_wr) m_en = int'(en_wd);
      foreach (rx_bits[i]) if (rx_on) m_en = m_en | (1 << rx_bits[i]);
      foreach (tx_bits[i]) if (tx_on) m_en = m_en | (1 << tx_bits[i]);
      foreach (rx_bits[i]) if (rx_off) m_en = m_en & ~(1 << rx_bits[i]);
      foreach (tx_bits[i]) if (tx_off) m_en = m_en & ~(1 << tx_bits[i]);
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk({cur_req, " model status"}, int'(status), m_sts);
      chk({cur_req, " model mask"}, int'(enable), m_en);
      chk({cur_req, " model irq"}, int'(irq), ((m_sts & m_en) != 0) ? 1 : 0);
    end
  end

  // one-cycle pulse of the given inputs; returns 2 ns after the consuming edge
  task automatic pulse(input logic [N-1:0] e, input logic sw, input logic [N-1:0] swd,
                       input logic ew, input logic [N-1:0] ewd,
                       input logic ron, input logic roff, input logic ton, input logic toff);
    evt = e; sts_wr = sw; sts_wd = swd; en_wr = ew; en_wd = ewd;
    rx_on = ron; rx_off = roff; tx_on = ton; tx_off = toff;
    @(posedge clk); #2;
    evt = '0; sts_wr = 0; sts_wd = '0; en_wr = 0; en_wd = '0;
    rx_on = 0; rx_off = 0; tx_on = 0; tx_off = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #20;
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset mask", int'(enable), 0);
    chk("R1 reset irq", int'(irq), 0);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #2;

    cur_req = "R2";
    pulse(14'h0001, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 event latched", int'(status), 'h0001);
    pulse(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 sticky after source drop", int'(status), 'h0001);
    cur_req = "R7";
    chk("R7 masked pending gives no irq", int'(irq), 0);
    pulse(0, 0, 0, 1, 14'h0001, 0, 0, 0, 0);
    chk("R7 unmask raises irq", int'(irq), 1);
    chk("R5 mask word loaded", int'(enable), 'h0001);
    cur_req = "R3";
    pulse(0, 1, 14'h0001, 0, 0, 0, 0, 0, 0);
    chk("R3 ack clears bit", int'(status), 0);
    chk("R6 irq drops with status", int'(irq), 0);
    pulse(14'h3FFF, 0, 0, 0, 0, 0, 0, 0, 0);
    pulse(0, 1, 14'h00F0, 0, 0, 0, 0, 0, 0);
    chk("R3 partial ack", int'(status), 'h3F0F);
    pulse(0, 1, 14'h3F0F, 0, 0, 0, 0, 0, 0);
    chk("R3 write-back clears all", int'(status), 0);
    cur_req = "R4";
    pulse(14'h0200, 1, 14'h0200, 0, 0, 0, 0, 0, 0);
    chk("R4 event beats ack", int'(status), 'h0200);

    cur_req = "R8";
    pulse(0, 0, 0, 1, 14'h0000, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 rx group on", int'(enable), 'h0BB0);
    chk("R6 pending bit9 unmasked", int'(irq), 1);
    cur_req = "R9";
    pulse(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 tx group on", int'(enable), 'h0BFC);
    cur_req = "R8";
    pulse(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 rx group off", int'(enable), 'h004C);
    chk("R6 irq low when bit9 masked", int'(irq), 0);
    cur_req = "R10";
    pulse(0, 0, 0, 1, 14'h3FFF, 0, 0, 0, 1);
    chk("R10 word write then tx off", int'(enable), 'h3FB3);
    pulse(0, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R10 tx off beats on", int'(enable), 'h3FB3);
    pulse(0, 0, 0, 1, 14'h0000, 1, 1, 0, 0);
    chk("R10 rx off beats on", int'(enable), 0);
    pulse(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 mask holds", int'(enable), 0);

    cur_req = "random R3 R4 R5 R6";
    for (int c = 0; c < 400; c++) begin
      pulse(14'($urandom) & 14'($urandom),
            ($urandom % 3) == 0, 14'($urandom),
            ($urandom % 5) == 0, 14'($urandom),
            ($urandom % 7) == 0, ($urandom % 7) == 0,
            ($urandom % 7) == 0, ($urandom % 7) == 0);
    end
    @(negedge clk);
    finish_run();
  end
endmodule